// File: doc/BRIEF.md
# Turbo-Mode Successive-Approximation Converter Read Controller

This block is the host side of a three-wire serial link to a successive-approximation converter that is run in its turbo read mode. It raises the convert strobe to start a conversion and then, while that conversion is still running, lowers the strobe again and uses it as a chip select. With the strobe low, it clocks out the result of the *previous* conversion on a gated serial clock derived from the system clock. The converter's configuration input is tied high for the whole operation, so a rising convert edge always means "start converting".

Two guard intervals keep the link clean. The first is a programmable quiet interval with the strobe high before the read may open. The second is a programmable quiet interval after the last serial clock fall before the next convert edge. On top of both sits a programmable throughput budget: the minimum number of system clocks from one convert edge to the next. A `start` pulse runs a single conversion-and-read. Holding `run` high chains them back to back. Each complete word is delivered on a parallel bus with a one-clock strobe. The very first read after reset carries a stale word, so the strobe is withheld for it.

Top module: `sar_turbo_reader`

## Requirements
- R1: While reset is held and directly after it, `adc_cnv`, `adc_sck` and `rd_valid` are low and `rd_count` is zero. `adc_sdi` is driven high at all times.
- R2: Every conversion holds `adc_cnv` high for exactly max(`cfg_quiet1`,1) system clocks before it falls to open the read window.
- R3: `adc_sck` is low whenever `adc_cnv` is high or the controller is idle. Within a read, each high and each low phase of `adc_sck` lasts max(`cfg_sck_half`,1) clocks. A read has exactly DATA_W (18 by default) falling edges.
- R4: One bit is taken at each `adc_sck` falling edge, using the value `adc_sdo` holds just before that edge, so the first bit taken is the one driven after `adc_cnv` fell. Bits fill `rd_data` MSB first (bit DATA_W-1 first, bit 0 last), and `rd_data` equals the result of the conversion started one convert edge earlier.
- R5: `adc_cnv` rises no sooner than max(`cfg_quiet2`,1)+1 clocks after the last `adc_sck` fall of the preceding read.
- R6: With `run` high, successive `adc_cnv` rising edges are exactly max(`cfg_cycle`, q1+2·DATA_W·h+q2+1) clocks apart. Here q1, q2 and h are the clamped values from R2, R5 and R3.
- R7: `rd_valid` is a one-clock pulse that starts at the same clock edge as the final `adc_sck` fall of a read. The first read after reset produces no pulse.
- R8: `rd_count` increases by exactly one, one clock after each `rd_valid` pulse.
- R9: With `run` low, a one-clock `start` pulse in idle produces exactly one conversion and read. The controller then returns to idle with `adc_cnv` low, and a run that ends also returns it there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Single-shot request, sampled in idle |
| run | input | 1 | Continuous-conversion enable |
| cfg_quiet1 | input | CNT_W | Clocks with convert high before the read opens (0 treated as 1) |
| cfg_quiet2 | input | CNT_W | Quiet clocks after the last serial clock fall (0 treated as 1) |
| cfg_cycle | input | CNT_W | Minimum clocks between convert edges |
| cfg_sck_half | input | DIV_W | Serial clock half period in system clocks (0 treated as 1) |
| adc_sdo | input | 1 | Serial data from the converter |
| adc_cnv | output | 1 | Convert strobe, low doubles as chip select |
| adc_sck | output | 1 | Gated serial clock |
| adc_sdi | output | 1 | Converter configuration input, held high |
| rd_data | output | DATA_W | Last complete result word |
| rd_valid | output | 1 | One-clock strobe for a fresh `rd_data` |
| rd_count | output | SCNT_W | Number of valid words delivered since reset |

## Verification
The bench builds the block with DATA_W=18, CNT_W=10, DIV_W=4 and falling-edge sampling. The narrow counters keep each period to a few hundred clocks. These values let the bench reach serial clocks at the fastest divide (half period of one clock) and at slower divides. They also cover the zero-clamp of both quiet settings and the half period, and throughput budgets that are both above and below the minimum the sequence itself needs, so both branches of R6 are exercised. A behavioural converter model follows the convert and clock edges, serves a computed word per conversion and lags one conversion behind, which makes the stale first read and the one-conversion offset of every later word visible at the ports.

// File: rtl/sar_turbo_pkg.sv
package sar_turbo_pkg;

   // Sequencer phases for one convert/read period.
   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_CONV   = 3'd1,
      ST_SHIFT  = 3'd2,
      ST_QUIET2 = 3'd3,
      ST_HOLD   = 3'd4
   } seq_state_t;

endpackage

// File: rtl/sar_sck_gen.sv
// Gated serial clock: divide-by-2h counter, idles low while disabled.
// rise_stb / fall_stb flag the clock edge at which sck will toggle.
module sar_sck_gen #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] half,
   output logic             sck,
   output logic             rise_stb,
   output logic             fall_stb
);

   logic [DIV_W-1:0] ph;
   logic [DIV_W-1:0] half_e;
   logic             wrap;

   assign half_e   = (half == '0) ? DIV_W'(1) : half;
   assign wrap     = en && (ph == half_e - DIV_W'(1));
   assign rise_stb = wrap && !sck;
   assign fall_stb = wrap && sck;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph  <= '0;
         sck <= 1'b0;
      end else if (!en) begin
         ph  <= '0;
         sck <= 1'b0;
      end else if (wrap) begin
         ph  <= '0;
         sck <= ~sck;
      end else begin
         ph  <= ph + DIV_W'(1);
      end
   end

endmodule

// File: rtl/sar_capture.sv
// Shift-in of one result word. The sampling edge is chosen at elaboration.
module sar_capture #(
   parameter int DATA_W         = 18,
   parameter bit SAMPLE_ON_FALL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              rise_stb,
   input  logic              fall_stb,
   input  logic              sdo,
   output logic [DATA_W-1:0] word,
   output logic              valid
);

   localparam int BCW = $clog2(DATA_W + 1);

   logic              cap;
   logic              unused_stb;
   logic [DATA_W-2:0] shreg;
   logic [BCW-1:0]    bit_cnt;
   logic              primed;

   generate
      if (SAMPLE_ON_FALL) begin : g_fall
         assign cap        = fall_stb;
         assign unused_stb = rise_stb;
      end else begin : g_rise
         assign cap        = rise_stb;
         assign unused_stb = fall_stb;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg   <= '0;
         bit_cnt <= '0;
         primed  <= 1'b0;
         word    <= '0;
         valid   <= 1'b0;
      end else begin
         valid <= 1'b0;
         if (clear) begin
            bit_cnt <= '0;
         end else if (cap && (bit_cnt < BCW'(DATA_W))) begin
            shreg   <= {shreg[DATA_W-3:0], sdo};
            bit_cnt <= bit_cnt + BCW'(1);
            if (bit_cnt == BCW'(DATA_W - 1)) begin
               word   <= {shreg, sdo};
               // the first word after reset belongs to no conversion of ours
               valid  <= primed;
               primed <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/sar_turbo_seq.sv
// Convert/read sequencer: CONV (quiet 1) -> SHIFT -> QUIET2 -> HOLD (cycle budget).
module sar_turbo_seq
   import sar_turbo_pkg::*;
#(
   parameter int DATA_W = 18,
   parameter int CNT_W  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             run,
   input  logic [CNT_W-1:0] quiet1,
   input  logic [CNT_W-1:0] quiet2,
   input  logic [CNT_W-1:0] cycle,
   input  logic             fall_stb,
   output logic             cnv,
   output logic             shift_en
);

   localparam int BCW = $clog2(DATA_W + 1);

   seq_state_t       st;
   logic [CNT_W-1:0] q_cnt;
   logic [CNT_W-1:0] cyc_cnt;
   logic [CNT_W-1:0] q1_e;
   logic [CNT_W-1:0] q2_e;
   logic [CNT_W-1:0] cyc_lim;
   logic [BCW-1:0]   f_cnt;

   assign q1_e     = (quiet1 == '0) ? CNT_W'(1) : quiet1;
   assign q2_e     = (quiet2 == '0) ? CNT_W'(1) : quiet2;
   assign cyc_lim  = (cycle == '0) ? '0 : cycle - CNT_W'(1);
   assign shift_en = (st == ST_SHIFT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         cnv     <= 1'b0;
         q_cnt   <= '0;
         cyc_cnt <= '0;
         f_cnt   <= '0;
      end else begin
         if (cyc_cnt != '1) cyc_cnt <= cyc_cnt + CNT_W'(1);
         case (st)
            ST_IDLE: begin
               if (start || run) begin
                  st      <= ST_CONV;
                  cnv     <= 1'b1;
                  q_cnt   <= '0;
                  cyc_cnt <= '0;
               end
            end
            ST_CONV: begin
               if (q_cnt == q1_e - CNT_W'(1)) begin
                  st    <= ST_SHIFT;
                  cnv   <= 1'b0;
                  f_cnt <= '0;
               end else begin
                  q_cnt <= q_cnt + CNT_W'(1);
               end
            end
            ST_SHIFT: begin
               if (fall_stb) begin
                  if (f_cnt == BCW'(DATA_W - 1)) begin
                     st    <= ST_QUIET2;
                     q_cnt <= '0;
                  end else begin
                     f_cnt <= f_cnt + BCW'(1);
                  end
               end
            end
            ST_QUIET2: begin
               if (q_cnt == q2_e - CNT_W'(1)) st <= ST_HOLD;
               else                           q_cnt <= q_cnt + CNT_W'(1);
            end
            ST_HOLD: begin
               if (cyc_cnt >= cyc_lim) begin
                  if (run) begin
                     st      <= ST_CONV;
                     cnv     <= 1'b1;
                     q_cnt   <= '0;
                     cyc_cnt <= '0;
                  end else begin
                     st <= ST_IDLE;
                  end
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // R9: no convert edge is issued from idle without a request
   a_r9_idle_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == ST_IDLE) && !start && !run) |=> !cnv);

endmodule

// File: rtl/sar_turbo_reader.sv
module sar_turbo_reader #(
   parameter int DATA_W         = 18,
   parameter int CNT_W          = 16,
   parameter int DIV_W          = 8,
   parameter int SCNT_W         = 16,
   parameter bit SAMPLE_ON_FALL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              run,
   input  logic [CNT_W-1:0]  cfg_quiet1,
   input  logic [CNT_W-1:0]  cfg_quiet2,
   input  logic [CNT_W-1:0]  cfg_cycle,
   input  logic [DIV_W-1:0]  cfg_sck_half,
   input  logic              adc_sdo,
   output logic              adc_cnv,
   output logic              adc_sck,
   output logic              adc_sdi,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic [SCNT_W-1:0] rd_count
);

   localparam int BCW = $clog2(DATA_W + 1);

   generate
      if (DATA_W < 4)  begin : g_bad_data  $error("DATA_W must be at least 4");  end
      if (CNT_W < 2)   begin : g_bad_cnt   $error("CNT_W must be at least 2");   end
      if (DIV_W < 1)   begin : g_bad_div   $error("DIV_W must be at least 1");   end
      if (SCNT_W < 1)  begin : g_bad_scnt  $error("SCNT_W must be at least 1");  end
   endgenerate

   logic shift_en;
   logic rise_stb;
   logic fall_stb;

   assign adc_sdi = 1'b1;

   sar_turbo_seq #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .run      (run),
      .quiet1   (cfg_quiet1),
      .quiet2   (cfg_quiet2),
      .cycle    (cfg_cycle),
      .fall_stb (fall_stb),
      .cnv      (adc_cnv),
      .shift_en (shift_en)
   );

   sar_sck_gen #(.DIV_W(DIV_W)) u_sck (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (shift_en),
      .half     (cfg_sck_half),
      .sck      (adc_sck),
      .rise_stb (rise_stb),
      .fall_stb (fall_stb)
   );

   sar_capture #(.DATA_W(DATA_W), .SAMPLE_ON_FALL(SAMPLE_ON_FALL)) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (adc_cnv),
      .rise_stb (rise_stb),
      .fall_stb (fall_stb),
      .sdo      (adc_sdo),
      .word     (rd_data),
      .valid    (rd_valid)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)        rd_count <= '0;
      else if (rd_valid) rd_count <= rd_count + SCNT_W'(1);
   end

   // ---------------- checker state (observes the pins only) ----------------
   logic             cnv_d, sck_d, read_seen;
   logic [CNT_W-1:0] hi_cnt;
   logic [CNT_W:0]   gap_cnt;
   logic [BCW-1:0]   pin_falls;
   logic [CNT_W-1:0] chk_q1;
   logic [CNT_W:0]   chk_q2;

   assign chk_q1 = (cfg_quiet1 == '0) ? CNT_W'(1) : cfg_quiet1;
   assign chk_q2 = {1'b0, ((cfg_quiet2 == '0) ? CNT_W'(1) : cfg_quiet2)} + (CNT_W+1)'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnv_d     <= 1'b0;
         sck_d     <= 1'b0;
         read_seen <= 1'b0;
         hi_cnt    <= '0;
         gap_cnt   <= '1;
         pin_falls <= '0;
      end else begin
         cnv_d <= adc_cnv;
         sck_d <= adc_sck;
         if (cnv_d && !adc_cnv) read_seen <= 1'b1;
         if (!adc_cnv)            hi_cnt <= '0;
         else if (hi_cnt != '1)   hi_cnt <= hi_cnt + CNT_W'(1);
         if (sck_d && !adc_sck)   gap_cnt <= (CNT_W+1)'(1);
         else if (gap_cnt != '1)  gap_cnt <= gap_cnt + (CNT_W+1)'(1);
         if (adc_cnv)                 pin_falls <= '0;
         else if (sck_d && !adc_sck)  pin_falls <= pin_falls + BCW'(1);
      end
   end

   a_r3_sck_low_while_cnv: assert property (@(posedge clk) disable iff (!rst_n)
      adc_cnv |-> !adc_sck);

   a_r2_quiet1_length: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(adc_cnv) |-> (hi_cnt == chk_q1));

   a_r5_quiet2_gap: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(adc_cnv) |-> (gap_cnt >= chk_q2));

   a_r3_full_word: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(adc_cnv) && read_seen) |-> (pin_falls == BCW'(DATA_W)));

   a_r7_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);

   a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> (rd_count == $past(rd_count) + SCNT_W'(1)));

endmodule

// File: tb/sar_turbo_reader_tb.sv
module sar_turbo_reader_tb;

   localparam int CLK_PERIOD = 10;
   localparam int DW   = 18;
   localparam int CW   = 10;
   localparam int DVW  = 4;
   localparam int SCW  = 16;
   localparam int NROW = 5;

   // stimulus table: quiet1, quiet2, sck half, cycle budget, expected period
   localparam int ROW_Q1  [NROW] = '{3, 5, 1, 0, 2};
   localparam int ROW_Q2  [NROW] = '{2, 4, 1, 0, 3};
   localparam int ROW_H   [NROW] = '{1, 2, 3, 1, 0};
   localparam int ROW_CYC [NROW] = '{10, 100, 0, 50, 0};
   localparam int ROW_PER [NROW] = '{42, 100, 111, 50, 42};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic run = 1'b0;
   logic [CW-1:0]  cfg_quiet1 = '0;
   logic [CW-1:0]  cfg_quiet2 = '0;
   logic [CW-1:0]  cfg_cycle = '0;
   logic [DVW-1:0] cfg_sck_half = '0;
   logic           adc_sdo;
   logic           adc_cnv, adc_sck, adc_sdi;
   logic [DW-1:0]  rd_data;
   logic           rd_valid;
   logic [SCW-1:0] rd_count;

   int n_checks = 0;
   int n_fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sar_turbo_reader #(.DATA_W(DW), .CNT_W(CW), .DIV_W(DVW), .SCNT_W(SCW),
                      .SAMPLE_ON_FALL(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .run(run),
      .cfg_quiet1(cfg_quiet1), .cfg_quiet2(cfg_quiet2), .cfg_cycle(cfg_cycle),
      .cfg_sck_half(cfg_sck_half), .adc_sdo(adc_sdo), .adc_cnv(adc_cnv),
      .adc_sck(adc_sck), .adc_sdi(adc_sdi), .rd_data(rd_data),
      .rd_valid(rd_valid), .rd_count(rd_count)
   );

   function automatic logic [DW-1:0] conv_value(input int n);
      logic [DW-1:0] x;
      x = DW'(n);
      return x * 18'h1A5C3 + 18'h2F0F1;
   endfunction

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // ---------------- behavioural converter (one conversion behind) ----------------
   logic          m_cnv_p, m_sck_p, m_en;
   logic [DW-1:0] m_shown, m_cur;
   int            m_n, m_bit, m_nf;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnv_p <= 1'b0; m_sck_p <= 1'b0; m_en <= 1'b0;
         m_shown <= '0;   m_cur <= '0;     m_n <= 0; m_bit <= 0; m_nf <= 0;
      end else begin
         m_cnv_p <= adc_cnv;
         m_sck_p <= adc_sck;
         if (adc_cnv && !m_cnv_p) begin
            m_shown <= m_cur;
            m_cur   <= conv_value(m_n);
            m_n     <= m_n + 1;
            m_en    <= 1'b0;
         end else if (!adc_cnv && m_cnv_p) begin
            m_en  <= 1'b1;
            m_bit <= DW - 1;
            m_nf  <= 0;
         end else if (m_sck_p && !adc_sck && m_en) begin
            if (m_nf == DW - 1) m_en <= 1'b0;
            else begin
               m_nf  <= m_nf + 1;
               m_bit <= m_bit - 1;
            end
         end
      end
   end
   // released data line reads low in the model
   assign adc_sdo = m_en ? m_shown[m_bit] : 1'b0;

   // ---------------- pin monitor, sampled on the falling clock edge ----------------
   int  q1_e, q2_e, h_e, exp_per;
   bit  chk_per = 1'b0;
   logic p_cnv, p_sck, p_valid;
   int  c_hi, c_gap, c_sh, c_per, c_fv, f_cnt;
   int  reads, rises, valid_seen, exp_idx;
   bit  have_read, per_ok;

   always @(negedge clk) begin
      if (!rst_n) begin
         p_cnv = 0; p_sck = 0; p_valid = 0;
         c_hi = 0; c_gap = 0; c_sh = 0; c_per = 0; c_fv = 0; f_cnt = 0;
         reads = 0; rises = 0; valid_seen = 0; exp_idx = 0;
         have_read = 0; per_ok = 0;
      end else begin
         c_hi++; c_gap++; c_sh++; c_per++; c_fv++;
         if (adc_sck && !p_sck) c_sh = 0;
         if (!adc_sck && p_sck) begin
            check(c_sh == h_e, "R3 sck high phase", c_sh, h_e);
            c_gap = 0; c_fv = 0; f_cnt++;
         end
         if (!adc_cnv && p_cnv) begin
            check(c_hi == q1_e, "R2 cnv high length", c_hi, q1_e);
            f_cnt = 0; reads++; have_read = 1;
         end
         if (adc_cnv && !p_cnv) begin
            check(!adc_sck, "R3 sck low at convert edge", adc_sck, 0);
            if (have_read) begin
               check(c_gap >= q2_e + 1, "R5 quiet gap", c_gap, q2_e + 1);
               check(f_cnt == DW, "R3 falls per read", f_cnt, DW);
            end
            if (chk_per && per_ok) check(c_per == exp_per, "R6 period", c_per, exp_per);
            c_per = 0; per_ok = 1; rises++; c_hi = 0;
         end
         if (rd_valid) begin
            check(rd_data == conv_value(exp_idx), "R4 word", rd_data, conv_value(exp_idx));
            check(c_fv == 0, "R7 valid timing", c_fv, 0);
            check(!p_valid, "R7 valid width", p_valid, 0);
            exp_idx++; valid_seen++;
         end
         p_valid = rd_valid; p_cnv = adc_cnv; p_sck = adc_sck;
      end
   end

   // ---------------- watchdog ----------------
   int wd = 0;
   always @(posedge clk) begin
      wd++;
      if (wd > 150000) begin
         n_fails++;
         $display("FAIL watchdog: actual %0d expected %0d", wd, 150000);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   task automatic set_cfg(input int q1, input int q2, input int h, input int cyc);
      cfg_quiet1   = CW'(q1);
      cfg_quiet2   = CW'(q2);
      cfg_sck_half = DVW'(h);
      cfg_cycle    = CW'(cyc);
      q1_e = (q1 == 0) ? 1 : q1;
      q2_e = (q2 == 0) ? 1 : q2;
      h_e  = (h == 0) ? 1 : h;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      // R1: reset state
      set_cfg(3, 2, 1, 10);
      do_reset();
      @(negedge clk);
      check(!adc_cnv, "R1 cnv after reset", adc_cnv, 0);
      check(!adc_sck, "R1 sck after reset", adc_sck, 0);
      check(!rd_valid, "R1 valid after reset", rd_valid, 0);
      check(rd_count == 0, "R1 count after reset", rd_count, 0);
      check(adc_sdi, "R1 sdi held high", adc_sdi, 1);

      // table walk: continuous run per row (R2..R8)
      for (int r = 0; r < NROW; r++) begin
         int guard;
         set_cfg(ROW_Q1[r], ROW_Q2[r], ROW_H[r], ROW_CYC[r]);
         exp_per = ROW_PER[r];
         do_reset();
         chk_per = 1'b1;
         @(negedge clk);
         run = 1'b1;
         guard = 0;
         while (valid_seen < 4 && guard < 5000) begin
            @(negedge clk);
            guard++;
         end
         check(valid_seen >= 4, "R6 words delivered in run", valid_seen, 4);
         run = 1'b0;
         repeat (400) @(negedge clk);
         check(!adc_cnv, "R9 idle after run ends", adc_cnv, 0);
         check(rd_count == SCW'(valid_seen), "R8 count matches pulses", rd_count, valid_seen);
         check(valid_seen == reads - 1, "R7 first read withheld", valid_seen, reads - 1);
         check(adc_sdi, "R1 sdi high during run", adc_sdi, 1);
      end

      // single-shot starts (R9, R7 stale first word, R4 one-behind)
      chk_per = 1'b0;
      set_cfg(3, 2, 1, 10);
      do_reset();
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (300) @(negedge clk);
      check(rises == 1, "R9 one conversion per start", rises, 1);
      check(valid_seen == 0, "R7 stale first word not flagged", valid_seen, 0);
      check(!adc_cnv, "R9 cnv low in idle", adc_cnv, 0);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (300) @(negedge clk);
      check(rises == 2, "R9 second start", rises, 2);
      check(valid_seen == 1, "R4 second shot returns first conversion", valid_seen, 1);
      check(rd_count == 1, "R8 count after shots", rd_count, 1);
      check(!adc_sck, "R3 sck idle low", adc_sck, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule